// File: doc/BRIEF.md
# CAN Controller SPI Sequencer

This block is the single SPI master in front of an external SPI-attached CAN controller, and it is the only sender on the CAN bus. After reset it brings the controller up. It sends the controller's reset instruction, waits a settle time, writes the three bit-timing registers for 1 Mbps and switches the controller to normal mode. When this is done it raises `init_done`. From then on it loads and launches transmit frames, and between frames it reads a set of controller registers into output mirrors.

Frames come from two sources. One is the host relay and the other is an injected reflex source. A gate input picks between them. While the gate is closed, only reflex strobes are honoured and host strobes are dropped. While the gate is open, only host strobes are honoured. There is no queue: a strobe that arrives while the sequencer is busy, or that the gate rejects, is lost.

Top module: `canseq_top`

## Requirements
- R1: The first SPI transaction after reset is the single byte 0xC0.
- R2: After the reset transaction, chip select stays high for at least SETTLE_CYC clock cycles before the next transaction starts.
- R3: Initialisation then performs four write transactions in this order: [0x02,0x2A,0x00], [0x02,0x29,0xC0], [0x02,0x28,0x80], [0x02,0x0F,0x00].
- R4: `init_done` is 0 from reset until chip select has risen at the end of the fourth initialisation write. After that it is 1 and stays 1.
- R5: A frame send consists of two transactions. The first is the 15-byte load [0x02, 0x31, id[10:3], {id[2:0],5'b0}, 0x00, 0x00, {4'b0,dlc}, data[7:0], data[15:8], …, data[63:56]]. It is followed by the 1-byte [0x81]. Bits go out MSB first in SPI mode 0.
- R6: When `rflx_active`=1 in the accepting cycle, a reflex strobe sends the reflex frame, and a host strobe in that cycle is dropped and never sent later.
- R7: When `rflx_active`=0 in the accepting cycle, a host strobe sends the host frame, and a reflex strobe is ignored.
- R8: A strobe that arrives while `busy`=1 is ignored.
- R9: Between any two transactions, chip select is high for at least 4*CLK_DIV cycles (two SCLK periods). SCLK is low whenever chip select is high.
- R10: After POLL_CYC idle cycles the block reads six registers in this order, each as [0x03, addr, 0x00]: 0x0E, 0x2A, 0x29, 0x28, 0x1C, 0x1D. The byte returned in each read's third byte appears on `mir_canstat`, `mir_cnf1`, `mir_cnf2`, `mir_cnf3`, `mir_tec` and `mir_rec` respectively.
- R11: `busy` is 1 from reset through initialisation and whenever chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | One-cycle strobe: send the host frame |
| host_id | input | 11 | Host frame standard identifier |
| host_dlc | input | 4 | Host frame data length code |
| host_data | input | 64 | Host frame payload, byte 0 in bits 7:0 |
| rflx_active | input | 1 | Gate: 1 selects the reflex source and blocks the host |
| rflx_req | input | 1 | One-cycle strobe: send the reflex frame |
| rflx_id | input | 11 | Reflex frame identifier |
| rflx_dlc | input | 4 | Reflex frame data length code |
| rflx_data | input | 64 | Reflex frame payload |
| spi_miso | input | 1 | Serial data from controller |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to controller |
| spi_csn | output | 1 | Active-low chip select |
| init_done | output | 1 | Controller initialisation complete |
| busy | output | 1 | Sequencer is not idle |
| mir_canstat | output | 8 | Last read of controller status |
| mir_cnf1 | output | 8 | Last read of bit-timing register 1 |
| mir_cnf2 | output | 8 | Last read of bit-timing register 2 |
| mir_cnf3 | output | 8 | Last read of bit-timing register 3 |
| mir_tec | output | 8 | Last read of transmit error counter |
| mir_rec | output | 8 | Last read of receive error counter |

## Verification
The bench decodes every chip-select window into a byte list and checks the power-up script against a fixed expected list, including the settle gap. It then sweeps all eight combinations of gate, host strobe and reflex strobe across four identifier and payload pairs. This shows whether the gate picks the right source, drops the loser and lets nothing through when no strobe is valid. A second strobe sent mid-send checks that nothing is queued. Two poll rounds with differently salted controller replies check the read order and that the mirrors track fresh data rather than stale values.

// File: rtl/canseq_pkg.sv
package canseq_pkg;

    localparam logic [7:0] INS_RESET = 8'hC0;
    localparam logic [7:0] INS_WRITE = 8'h02;
    localparam logic [7:0] INS_READ  = 8'h03;
    localparam logic [7:0] INS_RTS0  = 8'h81;
    localparam logic [7:0] ADR_TXB0  = 8'h31;

    localparam int NUM_INIT = 4;
    localparam int NUM_POLL = 6;
    localparam int LOAD_LEN = 15;

    typedef struct packed {
        logic [10:0] id;
        logic [3:0]  dlc;
        logic [63:0] data;
    } can_frame_t;

    typedef enum logic [2:0] {
        ST_RST_CMD,
        ST_SETTLE,
        ST_INIT_WR,
        ST_IDLE,
        ST_LOAD,
        ST_RTS,
        ST_POLL
    } seq_state_e;

    function automatic logic [7:0] init_addr(input logic [1:0] i);
        case (i)
            2'd0:    return 8'h2A;
            2'd1:    return 8'h29;
            2'd2:    return 8'h28;
            default: return 8'h0F;
        endcase
    endfunction

    function automatic logic [7:0] init_val(input logic [1:0] i);
        case (i)
            2'd0:    return 8'h00;
            2'd1:    return 8'hC0;
            2'd2:    return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] poll_addr(input logic [2:0] i);
        case (i)
            3'd0:    return 8'h0E;
            3'd1:    return 8'h2A;
            3'd2:    return 8'h29;
            3'd3:    return 8'h28;
            3'd4:    return 8'h1C;
            default: return 8'h1D;
        endcase
    endfunction

endpackage

// File: rtl/canseq_spi_byte.sv
module canseq_spi_byte #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx
);
    localparam int DCW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    typedef struct packed {
        logic           active;
        logic           sclk;
        logic [DCW-1:0] dcnt;
        logic [2:0]     bcnt;
        logic [7:0]     sh;
        logic [7:0]     rx;
        logic           done;
    } bsm_t;

    bsm_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.active) begin
            if (start) begin
                d.active = 1'b1;
                d.sh     = tx;
                d.dcnt   = '0;
                d.bcnt   = '0;
                d.sclk   = 1'b0;
            end
        end else if (q.dcnt == DCW'(CLK_DIV - 1)) begin
            d.dcnt = '0;
            if (!q.sclk) begin
                d.sclk = 1'b1;
                d.rx   = {q.rx[6:0], miso};
            end else begin
                d.sclk = 1'b0;
                d.sh   = {q.sh[6:0], 1'b0};
                d.bcnt = q.bcnt + 3'd1;
                if (q.bcnt == 3'd7) begin
                    d.active = 1'b0;
                    d.done   = 1'b1;
                end
            end
        end else begin
            d.dcnt = q.dcnt + DCW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk = q.sclk;
    assign mosi = q.sh[7];
    assign done = q.done;
    assign rx   = q.rx;

endmodule

// File: rtl/canseq_xfer.sv
module canseq_xfer #(
    parameter int CLK_DIV = 4,
    parameter int MAX_LEN = 15
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [$clog2(MAX_LEN+1)-1:0] len,
    input  logic [7:0]                 byte_in,
    output logic [$clog2(MAX_LEN+1)-1:0] byte_idx,
    output logic                       ready,
    output logic                       done,
    output logic [7:0]                 rx_last,
    input  logic                       miso,
    output logic                       sclk,
    output logic                       mosi,
    output logic                       csn
);
    localparam int LW  = $clog2(MAX_LEN + 1);
    localparam int GAP = 4 * CLK_DIV;
    localparam int GCW = $clog2(GAP + 1);

    typedef enum logic [1:0] {XP_IDLE, XP_RUN, XP_GAP} xph_e;

    typedef struct packed {
        xph_e          ph;
        logic          csn;
        logic [LW-1:0] idx;
        logic [LW-1:0] len;
        logic          nxt;
        logic [GCW-1:0] gcnt;
        logic          done;
        logic [7:0]    rx;
    } xfr_t;

    xfr_t q, d;
    logic b_start, b_done;
    logic [7:0] b_rx;

    canseq_spi_byte #(.CLK_DIV(CLK_DIV)) u_byte (
        .clk   (clk),
        .rst_n (rst_n),
        .start (b_start),
        .tx    (byte_in),
        .miso  (miso),
        .sclk  (sclk),
        .mosi  (mosi),
        .done  (b_done),
        .rx    (b_rx)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        b_start = 1'b0;
        case (q.ph)
            XP_IDLE: begin
                if (start) begin
                    d.ph    = XP_RUN;
                    d.csn   = 1'b0;
                    d.len   = len;
                    b_start = 1'b1;
                end
            end
            XP_RUN: begin
                if (q.nxt) begin
                    b_start = 1'b1;
                    d.nxt   = 1'b0;
                end else if (b_done) begin
                    if (q.idx == q.len - LW'(1)) begin
                        d.ph   = XP_GAP;
                        d.csn  = 1'b1;
                        d.gcnt = '0;
                        d.done = 1'b1;
                        d.rx   = b_rx;
                    end else begin
                        d.idx = q.idx + LW'(1);
                        d.nxt = 1'b1;
                    end
                end
            end
            default: begin
                if (q.gcnt == GCW'(GAP - 1)) begin
                    d.ph  = XP_IDLE;
                    d.idx = '0;
                end else begin
                    d.gcnt = q.gcnt + GCW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.ph  <= XP_IDLE;
            q.csn <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign byte_idx = q.idx;
    assign ready    = (q.ph == XP_IDLE);
    assign done     = q.done;
    assign rx_last  = q.rx;
    assign csn      = q.csn;

endmodule

// File: rtl/canseq_src_mux.sv
module canseq_src_mux
    import canseq_pkg::*;
(
    input  logic       gate_closed,
    input  logic       host_req,
    input  can_frame_t host_frame,
    input  logic       rflx_req,
    input  can_frame_t rflx_frame,
    output logic       sel_valid,
    output can_frame_t sel_frame
);
    always_comb begin
        if (gate_closed) begin
            sel_valid = rflx_req;
            sel_frame = rflx_frame;
        end else begin
            sel_valid = host_req;
            sel_frame = host_frame;
        end
    end

endmodule

// File: rtl/canseq_top.sv
module canseq_top
    import canseq_pkg::*;
#(
    parameter int CLK_DIV    = 4,
    parameter int SETTLE_CYC = 2000,
    parameter int POLL_CYC   = 20000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_req,
    input  logic [10:0] host_id,
    input  logic [3:0]  host_dlc,
    input  logic [63:0] host_data,
    input  logic        rflx_active,
    input  logic        rflx_req,
    input  logic [10:0] rflx_id,
    input  logic [3:0]  rflx_dlc,
    input  logic [63:0] rflx_data,
    input  logic        spi_miso,
    output logic        spi_sclk,
    output logic        spi_mosi,
    output logic        spi_csn,
    output logic        init_done,
    output logic        busy,
    output logic [7:0]  mir_canstat,
    output logic [7:0]  mir_cnf1,
    output logic [7:0]  mir_cnf2,
    output logic [7:0]  mir_cnf3,
    output logic [7:0]  mir_tec,
    output logic [7:0]  mir_rec
);
    localparam int LW  = $clog2(LOAD_LEN + 1);
    localparam int SCW = $clog2(SETTLE_CYC + 1);
    localparam int PCW = $clog2(POLL_CYC + 1);

    typedef struct packed {
        seq_state_e               st;
        logic                     wt;
        logic [2:0]               idx;
        logic [SCW-1:0]           cnt;
        logic [PCW-1:0]           pcnt;
        logic                     init_done;
        can_frame_t               frm;
        logic [NUM_POLL-1:0][7:0] mir;
    } seq_t;

    seq_t q, d;

    logic          x_start, x_ready, x_done;
    logic [LW-1:0] x_len, x_idx;
    logic [7:0]    x_byte, x_rx;
    logic          sel_valid;
    can_frame_t    sel_frame;
    logic [7:0]    dbyte [8];
    logic [15:0][7:0] load_img;

    canseq_src_mux u_mux (
        .gate_closed (rflx_active),
        .host_req    (host_req),
        .host_frame  ('{id: host_id, dlc: host_dlc, data: host_data}),
        .rflx_req    (rflx_req),
        .rflx_frame  ('{id: rflx_id, dlc: rflx_dlc, data: rflx_data}),
        .sel_valid   (sel_valid),
        .sel_frame   (sel_frame)
    );

    canseq_xfer #(.CLK_DIV(CLK_DIV), .MAX_LEN(LOAD_LEN)) u_xfer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (x_start),
        .len      (x_len),
        .byte_in  (x_byte),
        .byte_idx (x_idx),
        .ready    (x_ready),
        .done     (x_done),
        .rx_last  (x_rx),
        .miso     (spi_miso),
        .sclk     (spi_sclk),
        .mosi     (spi_mosi),
        .csn      (spi_csn)
    );

    // payload bytes of the latched frame, byte 0 first on the wire
    for (genvar g = 0; g < 8; g++) begin : g_dbyte
        assign dbyte[g] = q.frm.data[8*g +: 8];
    end

    always_comb begin
        load_img[0] = INS_WRITE;
        load_img[1] = ADR_TXB0;
        load_img[2] = q.frm.id[10:3];
        load_img[3] = {q.frm.id[2:0], 5'b0};
        load_img[4] = 8'h00;
        load_img[5] = 8'h00;
        load_img[6] = {4'b0, q.frm.dlc};
        for (int k = 0; k < 8; k++) load_img[7+k] = dbyte[k];
        load_img[15] = 8'h00;
    end

    // byte presented to the transfer engine for the current index
    always_comb begin
        x_len  = LW'(1);
        x_byte = 8'h00;
        case (q.st)
            ST_RST_CMD: x_byte = INS_RESET;
            ST_INIT_WR: begin
                x_len = LW'(3);
                case (x_idx)
                    LW'(0):  x_byte = INS_WRITE;
                    LW'(1):  x_byte = init_addr(q.idx[1:0]);
                    default: x_byte = init_val(q.idx[1:0]);
                endcase
            end
            ST_LOAD: begin
                x_len  = LW'(LOAD_LEN);
                x_byte = load_img[x_idx];
            end
            ST_RTS: x_byte = INS_RTS0;
            ST_POLL: begin
                x_len = LW'(3);
                case (x_idx)
                    LW'(0):  x_byte = INS_READ;
                    LW'(1):  x_byte = poll_addr(q.idx);
                    default: x_byte = 8'h00;
                endcase
            end
            default: ;
        endcase
    end

    always_comb begin
        d       = q;
        x_start = (q.st != ST_IDLE) && (q.st != ST_SETTLE) && !q.wt && x_ready;
        if (x_start) d.wt = 1'b1;
        if (x_done)  d.wt = 1'b0;
        case (q.st)
            ST_RST_CMD: begin
                if (x_done) begin
                    d.st  = ST_SETTLE;
                    d.cnt = '0;
                end
            end
            ST_SETTLE: begin
                if (q.cnt == SCW'(SETTLE_CYC - 1)) begin
                    d.st  = ST_INIT_WR;
                    d.idx = '0;
                end else begin
                    d.cnt = q.cnt + SCW'(1);
                end
            end
            ST_INIT_WR: begin
                if (x_done) begin
                    if (q.idx == 3'(NUM_INIT - 1)) begin
                        d.st        = ST_IDLE;
                        d.init_done = 1'b1;
                        d.pcnt      = '0;
                    end else begin
                        d.idx = q.idx + 3'd1;
                    end
                end
            end
            ST_IDLE: begin
                if (sel_valid) begin
                    d.frm = sel_frame;
                    d.st  = ST_LOAD;
                end else if (q.pcnt == PCW'(POLL_CYC - 1)) begin
                    d.st  = ST_POLL;
                    d.idx = '0;
                end else begin
                    d.pcnt = q.pcnt + PCW'(1);
                end
            end
            ST_LOAD: if (x_done) d.st = ST_RTS;
            ST_RTS: begin
                if (x_done) begin
                    d.st   = ST_IDLE;
                    d.pcnt = '0;
                end
            end
            ST_POLL: begin
                if (x_done) begin
                    for (int k = 0; k < NUM_POLL; k++)
                        if (q.idx == 3'(k)) d.mir[k] = x_rx;
                    if (q.idx == 3'(NUM_POLL - 1)) begin
                        d.st   = ST_IDLE;
                        d.pcnt = '0;
                    end else begin
                        d.idx = q.idx + 3'd1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_RST_CMD;
        end else begin
            q <= d;
        end
    end

    assign init_done   = q.init_done;
    assign busy        = (q.st != ST_IDLE);
    assign mir_canstat = q.mir[0];
    assign mir_cnf1    = q.mir[1];
    assign mir_cnf2    = q.mir[2];
    assign mir_cnf3    = q.mir[3];
    assign mir_tec     = q.mir[4];
    assign mir_rec     = q.mir[5];

endmodule

// File: rtl/canseq_chk.sv
module canseq_chk #(
    parameter int CLK_DIV = 4
) (
    input logic clk,
    input logic rst_n,
    input logic spi_sclk,
    input logic spi_mosi,
    input logic spi_csn,
    input logic init_done,
    input logic busy
);
    logic [15:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             hi_cnt <= 16'hFFFF;
        else if (!spi_csn)      hi_cnt <= 16'd0;
        else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
    end

    AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_csn) |-> (32'(hi_cnt) >= 4 * CLK_DIV)); // R9
    AST_SCLK_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        spi_csn |-> !spi_sclk); // R9
    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_csn && spi_sclk && $past(spi_sclk) && !$past(spi_csn)) |-> $stable(spi_mosi)); // R5
    AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done); // R4
    AST_INIT_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> spi_csn); // R4
    AST_BUSY_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_csn |-> busy); // R11

endmodule

bind canseq_top canseq_chk #(.CLK_DIV(CLK_DIV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .spi_csn   (spi_csn),
    .init_done (init_done),
    .busy      (busy)
);

// File: tb/canseq_top_tb.sv
module canseq_top_tb;
    localparam int DIV    = 2;
    localparam int SETTLE = 60;
    localparam int POLL   = 1500;
    localparam int MAXTR  = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_req = 1'b0, rflx_req = 1'b0, rflx_active = 1'b0;
    logic [10:0] host_id = '0, rflx_id = '0;
    logic [3:0]  host_dlc = '0, rflx_dlc = '0;
    logic [63:0] host_data = '0, rflx_data = '0;
    logic spi_miso = 1'b0;
    logic spi_sclk, spi_mosi, spi_csn, init_done, busy;
    logic [7:0] mir_canstat, mir_cnf1, mir_cnf2, mir_cnf3, mir_tec, mir_rec;

    always #2 clk = ~clk;

    canseq_top #(.CLK_DIV(DIV), .SETTLE_CYC(SETTLE), .POLL_CYC(POLL)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_id(host_id), .host_dlc(host_dlc), .host_data(host_data),
        .rflx_active(rflx_active), .rflx_req(rflx_req), .rflx_id(rflx_id),
        .rflx_dlc(rflx_dlc), .rflx_data(rflx_data),
        .spi_miso(spi_miso), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_csn(spi_csn),
        .init_done(init_done), .busy(busy),
        .mir_canstat(mir_canstat), .mir_cnf1(mir_cnf1), .mir_cnf2(mir_cnf2),
        .mir_cnf3(mir_cnf3), .mir_tec(mir_tec), .mir_rec(mir_rec)
    );

    int total = 0, bad = 0;
    int cyc = 0, ntr = 0, cur_len = 0, bitn = 0, init_rise = -1;
    logic [7:0] sh = '0;
    logic [7:0] salt = 8'h00;
    logic prev_csn = 1'b1, prev_sclk = 1'b0, prev_init = 1'b0;
    logic [7:0] tr_b [0:MAXTR-1][0:15];
    int tr_len [0:MAXTR-1];
    int tr_start [0:MAXTR-1];
    int tr_end [0:MAXTR-1];

    function automatic logic [7:0] regval(input logic [7:0] a, input logic [7:0] s);
        return (a * 8'd7) ^ s;
    endfunction

    function automatic logic [63:0] mkdata(input logic [10:0] id);
        return 64'h0123_4567_89AB_CDEF ^ {id, id, id, id, id, 9'h0};
    endfunction

    // controller model: decodes chip-select windows, answers reads
    always @(negedge clk) begin
        logic [7:0] rv;
        cyc++;
        if (prev_csn && !spi_csn) begin
            cur_len = 0; bitn = 0; tr_start[ntr] = cyc;
        end
        if (!prev_csn && spi_csn) begin
            tr_len[ntr] = cur_len; tr_end[ntr] = cyc;
            if (ntr < MAXTR - 1) ntr++;
        end
        if (!spi_csn && spi_sclk && !prev_sclk) begin
            sh = {sh[6:0], spi_mosi};
            bitn++;
            if (bitn == 8) begin
                if (cur_len < 16) tr_b[ntr][cur_len] = sh;
                cur_len++; bitn = 0;
            end
        end
        if (!spi_csn && cur_len == 2 && tr_b[ntr][0] == 8'h03) begin
            rv = regval(tr_b[ntr][1], salt);
            spi_miso = rv[7 - bitn];
        end else begin
            spi_miso = 1'b0;
        end
        if (init_done && !prev_init) init_rise = cyc;
        prev_csn = spi_csn; prev_sclk = spi_sclk; prev_init = init_done;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_bytes(input int k, input int n, input logic [7:0] exp [16], input string req);
        bit ok = (tr_len[k] == n);
        int first = -1;
        for (int i = 0; i < n; i++)
            if (ok && tr_b[k][i] != exp[i]) begin ok = 0; if (first < 0) first = i; end
        if (tr_len[k] != n) chk(0, req, "transaction length", tr_len[k], n);
        else chk(ok, req, $sformatf("tr%0d byte%0d", k, first),
                 first < 0 ? 0 : int'(tr_b[k][first]), first < 0 ? 0 : int'(exp[first]));
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic check_frame(input int k, input logic [10:0] id, input logic [3:0] dlc,
                               input logic [63:0] dat, input string req);
        logic [7:0] e [16];
        e[0] = 8'h02; e[1] = 8'h31; e[2] = id[10:3]; e[3] = {id[2:0], 5'b0};
        e[4] = 8'h00; e[5] = 8'h00; e[6] = {4'b0, dlc};
        for (int i = 0; i < 8; i++) e[7+i] = dat[8*i +: 8];
        e[15] = 8'h00;
        chk_bytes(k, 15, e, req);
        e[0] = 8'h81;
        chk_bytes(k + 1, 1, e, "R5");
    endtask

    // count frame loads (transactions starting with the write instruction) since mark
    task automatic scan_loads(input int mark, output int cnt, output int first);
        cnt = 0; first = -1;
        for (int k = mark; k < ntr; k++)
            if (tr_len[k] == 15 && tr_b[k][0] == 8'h02) begin
                if (first < 0) first = k;
                cnt++;
            end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] e [16];
        logic [10:0] hids [4];
        logic [10:0] rids [4];
        int mark, cnt, first, kr;
        hids[0] = 11'h000; hids[1] = 11'h7FF; hids[2] = 11'h123; hids[3] = 11'h555;
        rids[0] = 11'h150; rids[1] = 11'h155; rids[2] = 11'h156; rids[3] = 11'h157;
        for (int i = 0; i < 16; i++) e[i] = 8'h00;

        repeat (5) @(negedge clk);
        chk(spi_csn == 1'b1, "R9", "csn in reset", int'(spi_csn), 1);
        chk(spi_sclk == 1'b0, "R9", "sclk in reset", int'(spi_sclk), 0);
        chk(init_done == 1'b0, "R4", "init_done in reset", int'(init_done), 0);
        chk(busy == 1'b1, "R11", "busy in reset", int'(busy), 1);
        rst_n = 1'b1;

        while (!init_done) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(ntr == 5, "R3", "transactions during init", ntr, 5);
        e[0] = 8'hC0;
        chk_bytes(0, 1, e, "R1");
        chk(tr_start[1] - tr_end[0] >= SETTLE, "R2", "settle gap",
            tr_start[1] - tr_end[0], SETTLE);
        for (int w = 0; w < 4; w++) begin
            logic [7:0] a [4] = '{8'h2A, 8'h29, 8'h28, 8'h0F};
            logic [7:0] v [4] = '{8'h00, 8'hC0, 8'h80, 8'h00};
            e[0] = 8'h02; e[1] = a[w]; e[2] = v[w];
            chk_bytes(1 + w, 3, e, "R3");
        end
        chk(init_rise >= tr_end[4], "R4", "init_done rise cycle", init_rise, tr_end[4]);

        // sweep: gate x host strobe x reflex strobe over four frame pairs
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 8; c++) begin
                bit g = c[2], h = c[1], r = c[0];
                wait_idle();
                mark = ntr;
                host_id = hids[p]; host_dlc = hids[p][3:0]; host_data = mkdata(hids[p]);
                rflx_id = rids[p]; rflx_dlc = rids[p][3:0] ^ 4'hF; rflx_data = ~mkdata(rids[p]);
                rflx_active = g; host_req = h; rflx_req = r;
                @(negedge clk);
                host_req = 0; rflx_req = 0;
                repeat (60) @(negedge clk);
                wait_idle();
                repeat (4 * DIV + 2) @(negedge clk);
                scan_loads(mark, cnt, first);
                if (g && r) begin
                    chk(cnt == 1, "R6", "reflex frames sent", cnt, 1);
                    if (cnt == 1) check_frame(first, rids[p], rids[p][3:0] ^ 4'hF, ~mkdata(rids[p]), "R6");
                end else if (!g && h) begin
                    chk(cnt == 1, "R7", "host frames sent", cnt, 1);
                    if (cnt == 1) check_frame(first, hids[p], hids[p][3:0], mkdata(hids[p]), "R7");
                end else begin
                    chk(cnt == 0, g ? "R6" : "R7", "frames for rejected strobe", cnt, 0);
                end
                rflx_active = 0;
            end
        end

        // strobes during a send are not queued
        wait_idle();
        mark = ntr;
        host_id = 11'h2AA; host_dlc = 4'd8; host_data = mkdata(11'h2AA);
        host_req = 1; @(negedge clk); host_req = 0;
        repeat (20) @(negedge clk);
        chk(busy == 1'b1, "R11", "busy during send", int'(busy), 1);
        host_id = 11'h3CC; host_data = mkdata(11'h3CC);
        host_req = 1; @(negedge clk); host_req = 0;
        repeat (400) @(negedge clk);
        wait_idle();
        repeat (100) @(negedge clk);
        scan_loads(mark, cnt, first);
        chk(cnt == 1, "R8", "frames after strobe while busy", cnt, 1);
        if (cnt == 1) check_frame(first, 11'h2AA, 4'd8, mkdata(11'h2AA), "R8");

        // register read-back, two salts
        for (int s = 0; s < 2; s++) begin
            logic [7:0] pa [6] = '{8'h0E, 8'h2A, 8'h29, 8'h28, 8'h1C, 8'h1D};
            salt = (s == 0) ? 8'h3C : 8'hC5;
            repeat (2 * (POLL + 1000)) @(negedge clk);
            chk(mir_canstat == regval(8'h0E, salt), "R10", "mir_canstat", mir_canstat, regval(8'h0E, salt));
            chk(mir_cnf1 == regval(8'h2A, salt), "R10", "mir_cnf1", mir_cnf1, regval(8'h2A, salt));
            chk(mir_cnf2 == regval(8'h29, salt), "R10", "mir_cnf2", mir_cnf2, regval(8'h29, salt));
            chk(mir_cnf3 == regval(8'h28, salt), "R10", "mir_cnf3", mir_cnf3, regval(8'h28, salt));
            chk(mir_tec == regval(8'h1C, salt), "R10", "mir_tec", mir_tec, regval(8'h1C, salt));
            chk(mir_rec == regval(8'h1D, salt), "R10", "mir_rec", mir_rec, regval(8'h1D, salt));
            kr = -1;
            for (int k = 0; k < ntr; k++)
                if (tr_len[k] == 3 && tr_b[k][0] == 8'h03 && tr_b[k][1] == 8'h1D) kr = k;
            chk(kr >= 5, "R10", "poll round found", kr, 5);
            if (kr >= 5)
                for (int j = 0; j < 6; j++) begin
                    e[0] = 8'h03; e[1] = pa[j]; e[2] = 8'h00;
                    chk_bytes(kr - 5 + j, 3, e, "R10");
                end
        end

        // chip-select spacing over every recorded transaction pair
        for (int k = 1; k < ntr; k++)
            chk(tr_start[k] - tr_end[k-1] >= 4 * DIV, "R9", $sformatf("gap before tr%0d", k),
                tr_start[k] - tr_end[k-1], 4 * DIV);
        chk(ntr < MAXTR - 1, "R9", "recorder capacity", ntr, MAXTR - 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule